// File: doc/BRIEF.md
# Dot-Matrix Display Refresh Controller

This block drives a row-multiplexed LED matrix made of eight 5x7 character cells. A free-running scan timer steps through the seven dot rows. For each row it fetches one five-dot slice of every character's glyph and presents all forty column bits together with a one-hot row select. Each character comes from an 8-bit code on the character input bus. When the top bit of the code is clear, the low seven bits go to an external font lookup port. When the top bit is set, the low four bits pick one of sixteen user-defined glyphs through a second lookup port. The font contents and the user glyph storage sit outside the block and answer combinationally.

Three controls shape what is shown. A 3-bit brightness code sets the share of every row slot during which the row is lit. A flash-enable bit, combined with a per-character flash mask, makes selected characters go dark on alternate halves of a slow period. A global blink bit darkens every character on those same halves and overrides the flash settings. All timing comes from one counter chain that clears on reset, so several instances on a common clock and reset stay in step.

Top module: `dmx_refresh_ctrl`

## Requirements
- R1: While `rst_n` is low, `row_sel_o` and `col_o` are all zero.
- R2: Counting scan position p = 0, 1, 2, ... from the first rising edge after reset release, row r (row_sel_o bit r, 0 = top) owns positions 32r to 32r+31 of each 224-clock frame. Rows run in order 0 to 6 and the sequence repeats every 224 clocks. The output register adds one cycle: `row_sel_o` after edge n shows position n-1.
- R3: A row slot is split into 16 sub-slots of 2 clocks. The row is lit in sub-slot k when k is below the on-count for `bright_i`: 0→15, 1→12, 2→8, 3→6, 4→4, 5→3, 6→2, 7→0. Code 7 never lights a row.
- R4: For a code with bit 7 = 0, `font_code_o` for that character carries code bits 6:0. While the row is lit, the character's columns equal the `font_bits_i` slice returned for row `glyph_row_o`.
- R5: For a code with bit 7 = 1, `udc_idx_o` carries code bits 3:0 and the columns equal the `udc_bits_i` slice. Code bits 6:4 have no effect.
- R6: Character i (code at `char_codes_i[8i+7:8i]`) occupies `col_o[39-5i : 35-5i]`. Glyph bit 4 is the leftmost column and drives the highest bit of that group. `col_o[39]` is the leftmost column of character 0.
- R7: The flash period is 28,672 clocks (128 frames). Frames 0 to 63 after reset are the visible half and frames 64 to 127 are the dark half. In the dark half, a character with `flash_en_i` = 1 and its `flash_mask_i` bit = 1 shows all-zero columns.
- R8: With `flash_en_i` = 0, `flash_mask_i` has no effect on `col_o`.
- R9: With `blink_i` = 1, every character shows all-zero columns in the dark half, whatever the flash settings.
- R10: Flash and blink never alter `row_sel_o`. The row timing of R2 and R3 continues unchanged.
- R11: `col_o` is all zero in every cycle where `row_sel_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low reset; clears all counters and outputs |
| char_codes_i | input | 64 | Eight character codes, character i at bits 8i+7:8i |
| bright_i | input | 3 | Brightness code, 0 = full, 7 = dark |
| flash_en_i | input | 1 | Enables per-character flash |
| blink_i | input | 1 | Blinks the whole display |
| flash_mask_i | input | 8 | Per-character flash select, bit i = character i |
| font_code_o | output | 56 | 7-bit font address for each character, character i at 7i+6:7i |
| font_bits_i | input | 40 | Font row data for each character, character i at 5i+4:5i |
| udc_idx_o | output | 32 | 4-bit user glyph index for each character, character i at 4i+3:4i |
| udc_bits_i | input | 40 | User glyph row data for each character, character i at 5i+4:5i |
| glyph_row_o | output | 3 | Row index presented to both lookup ports |
| row_sel_o | output | 7 | One-hot row drive, bit 0 = top row |
| col_o | output | 40 | Column drive, bit 39 = leftmost column of character 0 |

## Verification
Each output is one register stage past the scan counters. The bench therefore counts rising edges since reset release and predicts that the value after edge n belongs to scan position n-1, from which it derives the row, the sub-slot and the flash half. Inputs change only at falling edges, so they take effect at the very next rising edge, and outputs are compared at every falling edge across whole frames against a model built from the requirements. The flash and blink scenarios start several hundred cycles inside a visible or dark half, so no check depends on the exact cycle at which the half changes.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   localparam int CODE_W   = 8;
   localparam int ASCII_W  = 7;
   localparam int UDC_W    = 4;
   localparam int SUBSLOTS = 16;
   localparam int SUB_W    = 4;
   localparam int BRIGHT_W = 3;

   typedef enum logic {
      SRC_FONT = 1'b0,
      SRC_UDC  = 1'b1
   } glyph_src_e;

   typedef logic [SUB_W-1:0] sub_t;

   // lit sub-slots (of 16) per brightness code; 15 is the full-intensity reference
   function automatic logic [SUB_W:0] duty_on(input logic [BRIGHT_W-1:0] code);
      logic [SUB_W:0] n;
      case (code)
         3'd0:    n = 5'd15;
         3'd1:    n = 5'd12;
         3'd2:    n = 5'd8;
         3'd3:    n = 5'd6;
         3'd4:    n = 5'd4;
         3'd5:    n = 5'd3;
         3'd6:    n = 5'd2;
         default: n = 5'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dmx_scan_timer.sv
module dmx_scan_timer
   import dmx_pkg::*;
#(
   parameter int ROWS         = 7,
   parameter int SLOT_CLKS    = 32,
   parameter int FLASH_FRAMES = 128,
   localparam int ROW_W       = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [ROW_W-1:0] row_o,
   output sub_t             sub_o,
   output logic             off_phase_o
);

   localparam int SLOT_W  = $clog2(SLOT_CLKS);
   localparam int FR_W    = $clog2(FLASH_FRAMES);
   localparam int SUB_DIV = SLOT_CLKS / SUBSLOTS;
   localparam int DIV_SH  = $clog2(SUB_DIV);

   initial begin : elab_checks
      assert (SLOT_CLKS >= SUBSLOTS && SLOT_CLKS % SUBSLOTS == 0)
         else $error("SLOT_CLKS must be a multiple of %0d", SUBSLOTS);
      assert (ROWS >= 2)
         else $error("ROWS must be at least 2");
      assert (FLASH_FRAMES >= 2 && FLASH_FRAMES % 2 == 0)
         else $error("FLASH_FRAMES must be even and at least 2");
   end

   logic [SLOT_W-1:0] slot_q;
   logic [ROW_W-1:0]  row_q;
   logic [FR_W-1:0]   frame_q;
   logic              slot_end;
   logic              frame_end;

   assign slot_end  = (slot_q == SLOT_W'(SLOT_CLKS - 1));
   assign frame_end = slot_end && (row_q == ROW_W'(ROWS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q  <= '0;
         row_q   <= '0;
         frame_q <= '0;
      end else begin
         if (slot_end) begin
            slot_q <= '0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
         if (frame_end) begin
            row_q <= '0;
         end else if (slot_end) begin
            row_q <= row_q + 1'b1;
         end
         if (frame_end) begin
            if (frame_q == FR_W'(FLASH_FRAMES - 1)) begin
               frame_q <= '0;
            end else begin
               frame_q <= frame_q + 1'b1;
            end
         end
      end
   end

   logic [SLOT_W-1:0] scaled;

   generate
      if ((1 << DIV_SH) == SUB_DIV) begin : g_shift_sub
         assign scaled = slot_q >> DIV_SH;
      end else begin : g_div_sub
         assign scaled = slot_q / SLOT_W'(SUB_DIV);
      end
   endgenerate

   assign row_o       = row_q;
   assign sub_o       = scaled[SUB_W-1:0];
   assign off_phase_o = (frame_q >= FR_W'(FLASH_FRAMES / 2));

   // R2: the row index stays inside the matrix
   p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= ROW_W'(ROWS - 1));

   // R2: the row only moves at the end of its slot
   p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_end |=> $stable(row_q));

   // R7: the flash half only changes at a frame boundary
   p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(off_phase_o));

endmodule

// File: rtl/dmx_glyph_sel.sv
module dmx_glyph_sel
   import dmx_pkg::*;
#(
   parameter int COLS = 5
) (
   input  logic [CODE_W-1:0]  code_i,
   input  logic [COLS-1:0]    font_bits_i,
   input  logic [COLS-1:0]    udc_bits_i,
   input  logic               blank_i,
   output logic [ASCII_W-1:0] font_code_o,
   output logic [UDC_W-1:0]   udc_idx_o,
   output logic [COLS-1:0]    cols_o
);

   glyph_src_e      src;
   logic [COLS-1:0] picked;

   assign src         = glyph_src_e'(code_i[CODE_W-1]);
   assign font_code_o = code_i[ASCII_W-1:0];
   assign udc_idx_o   = code_i[UDC_W-1:0];

   always_comb begin
      picked = (src == SRC_UDC) ? udc_bits_i : font_bits_i;
      cols_o = blank_i ? '0 : picked;
   end

endmodule

// File: rtl/dmx_row_drive.sv
module dmx_row_drive
   import dmx_pkg::*;
#(
   parameter int ROWS      = 7,
   parameter int NUM_CHARS = 8,
   parameter int COLS      = 5,
   localparam int ROW_W    = $clog2(ROWS),
   localparam int COL_W    = NUM_CHARS * COLS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ROW_W-1:0]    row_i,
   input  sub_t                sub_i,
   input  logic [BRIGHT_W-1:0] bright_i,
   input  logic [COL_W-1:0]    cols_i,
   output logic [ROWS-1:0]     row_sel_o,
   output logic [COL_W-1:0]    col_o
);

   logic [SUB_W:0]  on_cnt;
   logic            lit;
   logic [ROWS-1:0] row_dec;

   assign on_cnt = duty_on(bright_i);
   assign lit    = ({1'b0, sub_i} < on_cnt);

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
         assign row_dec[r] = (row_i == ROW_W'(r));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_sel_o <= '0;
         col_o     <= '0;
      end else begin
         row_sel_o <= lit ? row_dec : '0;
         col_o     <= lit ? cols_i  : '0;
      end
   end

   // R2: at most one row driven
   p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_sel_o));

   // R3: the dark brightness code never lights a row
   p_blank_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bright_i == 3'b111) |=> (row_sel_o == '0));

   // R3: the last sub-slot of every row is dark
   p_last_sub_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_i == sub_t'(SUBSLOTS - 1)) |=> (row_sel_o == '0));

   // R11: no column drive without a row
   p_dark_cols_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sel_o == '0) |-> (col_o == '0));

endmodule

// File: rtl/dmx_refresh_ctrl.sv
module dmx_refresh_ctrl
   import dmx_pkg::*;
#(
   parameter int NUM_CHARS    = 8,
   parameter int ROWS         = 7,
   parameter int COLS         = 5,
   parameter int SLOT_CLKS    = 32,
   parameter int FLASH_FRAMES = 128,
   localparam int ROW_W       = $clog2(ROWS),
   localparam int COL_W       = NUM_CHARS * COLS
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CHARS*CODE_W-1:0]   char_codes_i,
   input  logic [BRIGHT_W-1:0]           bright_i,
   input  logic                          flash_en_i,
   input  logic                          blink_i,
   input  logic [NUM_CHARS-1:0]          flash_mask_i,
   output logic [NUM_CHARS*ASCII_W-1:0]  font_code_o,
   input  logic [COL_W-1:0]              font_bits_i,
   output logic [NUM_CHARS*UDC_W-1:0]    udc_idx_o,
   input  logic [COL_W-1:0]              udc_bits_i,
   output logic [ROW_W-1:0]              glyph_row_o,
   output logic [ROWS-1:0]               row_sel_o,
   output logic [COL_W-1:0]              col_o
);

   initial begin : elab_checks
      assert (NUM_CHARS >= 1)
         else $error("NUM_CHARS must be at least 1");
      assert (COLS >= 1)
         else $error("COLS must be at least 1");
   end

   logic [ROW_W-1:0] row_idx;
   sub_t             sub_idx;
   logic             off_phase;
   logic [COL_W-1:0] cols_next;

   dmx_scan_timer #(
      .ROWS         (ROWS),
      .SLOT_CLKS    (SLOT_CLKS),
      .FLASH_FRAMES (FLASH_FRAMES)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .row_o       (row_idx),
      .sub_o       (sub_idx),
      .off_phase_o (off_phase)
   );

   assign glyph_row_o = row_idx;

   generate
      for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
         logic blank;
         assign blank = off_phase && (blink_i || (flash_en_i && flash_mask_i[i]));

         dmx_glyph_sel #(
            .COLS (COLS)
         ) u_sel (
            .code_i      (char_codes_i[i*CODE_W +: CODE_W]),
            .font_bits_i (font_bits_i[i*COLS +: COLS]),
            .udc_bits_i  (udc_bits_i[i*COLS +: COLS]),
            .blank_i     (blank),
            .font_code_o (font_code_o[i*ASCII_W +: ASCII_W]),
            .udc_idx_o   (udc_idx_o[i*UDC_W +: UDC_W]),
            .cols_o      (cols_next[(NUM_CHARS-1-i)*COLS +: COLS])
         );
      end
   endgenerate

   dmx_row_drive #(
      .ROWS      (ROWS),
      .NUM_CHARS (NUM_CHARS),
      .COLS      (COLS)
   ) u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_i     (row_idx),
      .sub_i     (sub_idx),
      .bright_i  (bright_i),
      .cols_i    (cols_next),
      .row_sel_o (row_sel_o),
      .col_o     (col_o)
   );

   // R9: blink in the dark half clears every column
   p_blink_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (blink_i && off_phase) |=> (col_o == '0));

   // R10: at full brightness the row is driven in every sub-slot but the last, in either half
   p_full_lit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((bright_i == 3'b000) && (sub_idx != sub_t'(SUBSLOTS - 1))) |=> (row_sel_o != '0));

endmodule

// File: tb/dmx_refresh_ctrl_tb.sv
module dmx_refresh_ctrl_tb;

   localparam int NCH        = 8;
   localparam int ROWS       = 7;
   localparam int COLS       = 5;
   localparam int SLOT       = 32;
   localparam int FRAMES     = 128;
   localparam int FRAME_CLKS = ROWS * SLOT;
   localparam int HALF_CLKS  = FRAME_CLKS * FRAMES / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] codes = '0;
   logic [2:0]  bright = '0;
   logic        flash_en = 1'b0;
   logic        blink = 1'b0;
   logic [7:0]  fmask = '0;
   logic [55:0] font_code;
   logic [39:0] font_bits;
   logic [31:0] udc_idx;
   logic [39:0] udc_bits;
   logic [2:0]  grow;
   logic [6:0]  row_sel;
   logic [39:0] col;

   int checks = 0;
   int failures = 0;
   int ncyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dmx_refresh_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .char_codes_i (codes),
      .bright_i     (bright),
      .flash_en_i   (flash_en),
      .blink_i      (blink),
      .flash_mask_i (fmask),
      .font_code_o  (font_code),
      .font_bits_i  (font_bits),
      .udc_idx_o    (udc_idx),
      .udc_bits_i   (udc_bits),
      .glyph_row_o  (grow),
      .row_sel_o    (row_sel),
      .col_o        (col)
   );

   function automatic logic [4:0] font_model(logic [6:0] c, logic [2:0] r);
      return 5'((int'(c) * 5 + int'(r) * 3 + 1) % 32);
   endfunction

   function automatic logic [4:0] udc_model(logic [3:0] idx, logic [2:0] r);
      return 5'(((int'(idx) * 7) ^ (int'(r) * 9) ^ 21) % 32);
   endfunction

   // external lookup memories
   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         font_bits[i*5 +: 5] = font_model(font_code[i*7 +: 7], grow);
         udc_bits[i*5 +: 5]  = udc_model(udc_idx[i*4 +: 4], grow);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) ncyc <= 0;
      else        ncyc <= ncyc + 1;
   end

   function automatic int on_tab(logic [2:0] b);
      case (b)
         3'd0: return 15;
         3'd1: return 12;
         3'd2: return 8;
         3'd3: return 6;
         3'd4: return 4;
         3'd5: return 3;
         3'd6: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic logic [6:0] exp_row(int n);
      int s, f, r, sub;
      s = n - 1;
      f = s % FRAME_CLKS;
      r = f / SLOT;
      sub = (f % SLOT) / 2;
      if (sub < on_tab(bright)) return 7'(1 << r);
      return 7'd0;
   endfunction

   function automatic logic [39:0] exp_col(int n);
      int s, f, r, sub;
      bit off;
      logic [39:0] v;
      logic [7:0] c;
      logic [4:0] g;
      s = n - 1;
      f = s % FRAME_CLKS;
      r = f / SLOT;
      sub = (f % SLOT) / 2;
      v = '0;
      if (sub >= on_tab(bright)) return v;
      off = ((s / FRAME_CLKS) % FRAMES) >= (FRAMES / 2);
      for (int i = 0; i < NCH; i++) begin
         c = codes[i*8 +: 8];
         g = c[7] ? udc_model(c[3:0], 3'(r)) : font_model(c[6:0], 3'(r));
         if (off && (blink || (flash_en && fmask[i]))) g = '0;
         v[(NCH-1-i)*COLS +: COLS] = g;
      end
      return v;
   endfunction

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // compares every cycle of a window against the model
   task automatic run_window(int n, string tag_row, string tag_col);
      int bad_r = 0;
      int bad_c = 0;
      int stray = 0;
      logic [6:0]  ra = '0, re = '0;
      logic [39:0] ca = '0, ce = '0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (row_sel !== exp_row(ncyc)) begin
            if (bad_r == 0) begin ra = row_sel; re = exp_row(ncyc); end
            bad_r++;
         end
         if (col !== exp_col(ncyc)) begin
            if (bad_c == 0) begin ca = col; ce = exp_col(ncyc); end
            bad_c++;
         end
         if (row_sel == 7'd0 && col != 40'd0) stray++;
      end
      check(bad_r == 0, tag_row, "row_sel", 64'(ra), 64'(re));
      check(bad_c == 0, tag_col, "col", 64'(ca), 64'(ce));
      check(stray == 0, "R11", "cols without row", 64'(stray), 64'd0);
   endtask

   task automatic wait_until(int target);
      while (ncyc < target) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      codes = 64'h4142_4344_4546_4748;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(row_sel == 7'd0, "R1", "row_sel in reset", 64'(row_sel), 64'd0);
         check(col == 40'd0, "R1", "col in reset", 64'(col), 64'd0);
      end
      rst_n = 1'b1;
   endtask

   task automatic t_flash_visible;
      flash_en = 1'b1;
      fmask    = 8'hFF;
      run_window(FRAME_CLKS, "R2", "R7");
      flash_en = 1'b0;
      fmask    = 8'h00;
   endtask

   task automatic t_brightness;
      int lit3, rise_at, period;
      logic prev0;
      for (int b = 0; b < 8; b++) begin
         bright = 3'(b);
         run_window(FRAME_CLKS, "R3", "R4");
      end
      bright = 3'd1;
      lit3 = 0; rise_at = -1; period = 0; prev0 = row_sel[0];
      for (int k = 0; k < 2 * FRAME_CLKS; k++) begin
         @(negedge clk);
         if (k < FRAME_CLKS && row_sel[3]) lit3++;
         if (row_sel[0] && !prev0) begin
            if (rise_at >= 0 && period == 0) period = ncyc - rise_at;
            rise_at = ncyc;
         end
         prev0 = row_sel[0];
      end
      check(lit3 == 24, "R3", "lit cycles row 3 code 1", 64'(lit3), 64'd24);
      check(period == FRAME_CLKS, "R2", "row 0 repeat period", 64'(period), 64'(FRAME_CLKS));
   endtask

   task automatic t_ascii;
      bright = 3'd0;
      codes  = 64'h7F00_5A20_3161_0D40;
      run_window(FRAME_CLKS, "R2", "R4");
   endtask

   task automatic t_udc;
      bright = 3'd0;
      codes  = 64'hF3_83_8F_FA_9C_80_41_E5;
      run_window(FRAME_CLKS, "R2", "R5");
      codes  = 64'h00_00_00_00_00_00_00_87;
      run_window(FRAME_CLKS, "R2", "R6");
   endtask

   task automatic t_flash_dark;
      codes    = 64'h4142_8344_4546_9748;
      bright   = 3'd2;
      wait_until(HALF_CLKS + 300);
      flash_en = 1'b1;
      fmask    = 8'h24;
      run_window(FRAME_CLKS, "R10", "R7");
      flash_en = 1'b0;
      run_window(FRAME_CLKS, "R10", "R8");
      blink    = 1'b1;
      fmask    = 8'h00;
      run_window(FRAME_CLKS, "R10", "R9");
      wait_until(2 * HALF_CLKS + 300);
      flash_en = 1'b1;
      fmask    = 8'hFF;
      run_window(FRAME_CLKS, "R10", "R7");
      blink    = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired at cycle %0d", ncyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_flash_visible();
      t_brightness();
      t_ascii();
      t_udc();
      t_flash_dark();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule